// File: doc/BRIEF.md
# Execution-Protection Security Monitor

The block watches every address the CPU puts on its bus and raises one sticky violation flag when that address breaks a protection rule. Two rules are always active. The first is that no instruction may be fetched from the firmware RAM. The second is that no access of any kind may reach the part of the RAM address range that lies above the physically present RAM. A third rule is armed by software. It forbids instruction fetches from an application-defined address window, typically the stack or heap.

Software uses three registers. At 0x61 it writes the lowest address of the window, and at 0x62 the highest. It then writes a one in bit 0 of the control register at 0x60. From that point on the window rule stays armed and both bounds are locked until the next system reset. The violation output stays set until that same reset, so a later response stage sees a steady level.

Top module: `exec_guard`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), `violation` is 0. Reads of 0x60, 0x61 and 0x62 all return 0.
- R2: A fetch (`bus_valid`=1, `bus_fetch`=1) at any address from FW_BASE to FW_BASE+FW_SIZE-1, both ends included, sets `violation`.
- R3: A fetch or a data access at any address from RAM_BASE+RAM_SIZE to RAM_BASE+RAM_SPAN-1 sets `violation`. Address RAM_BASE+RAM_SIZE-1 does not set it.
- R4: Once the window is armed, a fetch at an address A with first <= A <= last (unsigned, both ends included) sets `violation`. When last < first the window is empty.
- R5: A data access (`bus_fetch`=0) inside the window or inside the firmware RAM does not set `violation`. A fetch inside the window while the window is not armed does not set it either.
- R6: A write to 0x60 with bit 0 = 1 arms the window. A write to 0x60 with bit 0 = 0 changes nothing, so the window cannot be disarmed. A read of 0x60 returns the armed state in bit 0, with the other bits 0.
- R7: While the window is unarmed, writes to 0x61 and 0x62 load the first and last bounds, and reads return them. Once the window is armed, writes to those addresses are ignored and reads keep returning the old bounds.
- R8: `violation` rises at the first clock edge that samples an offending access and stays 1 until reset, whatever accesses follow.
- R9: `reg_rdata` follows `reg_addr` combinationally. Any register address other than 0x60 to 0x62 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_cs | input | 1 | Register access select |
| reg_we | input | 1 | Register write strobe, qualified by reg_cs |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| bus_valid | input | 1 | CPU bus carries an access this cycle |
| bus_fetch | input | 1 | The access is an instruction fetch |
| bus_addr | input | 32 | Byte address of the access |
| violation | output | 1 | Sticky protection violation flag |

## Verification
The assertions assume that `bus_valid`, `bus_fetch` and `bus_addr` are stable across each sampling edge. They also assume a register write lasts exactly one cycle with `reg_cs` and `reg_we` both high. The bench drives every input on the falling edge and holds each access or write for a single cycle. This keeps the stimulus inside those assumptions. Random addresses are taken from buckets placed next to each region and window boundary, so the inclusive edges are hit often. Each random trial starts from reset and issues one access, so the sticky flag from one trial does not hide the result of the next.

// File: rtl/secmon_pkg.sv
package secmon_pkg;

    parameter int unsigned ADDR_W = 32;
    parameter int unsigned DATA_W = 32;
    parameter int unsigned REG_AW = 8;

    localparam logic [REG_AW-1:0] REG_CTRL  = 8'h60;
    localparam logic [REG_AW-1:0] REG_FIRST = 8'h61;
    localparam logic [REG_AW-1:0] REG_LAST  = 8'h62;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic  valid;
        logic  fetch;
        addr_t addr;
    } access_t;

    typedef struct packed {
        logic  armed;
        addr_t first;
        addr_t last;
    } window_t;

    typedef struct packed {
        logic fw_fetch;
        logic ram_oob;
        logic win_fetch;
    } hits_t;

    function automatic logic in_span(input addr_t a, input addr_t lo, input addr_t hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/secmon_regs.sv
module secmon_regs
    import secmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_cs,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  data_t             reg_wdata,
    output data_t             reg_rdata,
    output window_t           win
);

    window_t win_q;
    logic    wr;

    assign wr  = reg_cs && reg_we;
    assign win = win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else if (wr) begin
            unique case (reg_addr)
                REG_CTRL:  if (reg_wdata[0]) win_q.armed <= 1'b1;
                REG_FIRST: if (!win_q.armed) win_q.first <= addr_t'(reg_wdata);
                REG_LAST:  if (!win_q.armed) win_q.last  <= addr_t'(reg_wdata);
                default:   ;
            endcase
        end
    end

    always_comb begin
        unique case (reg_addr)
            REG_CTRL:  reg_rdata = data_t'(win_q.armed);
            REG_FIRST: reg_rdata = data_t'(win_q.first);
            REG_LAST:  reg_rdata = data_t'(win_q.last);
            default:   reg_rdata = '0;
        endcase
    end

    AST_ARM_ONE_WAY: assert property (@(posedge clk) disable iff (rst)
        win_q.armed |=> win_q.armed); // R6

    AST_BOUNDS_LOCKED: assert property (@(posedge clk) disable iff (rst)
        win_q.armed |=> ($stable(win_q.first) && $stable(win_q.last))); // R7

endmodule

// File: rtl/secmon_checks.sv
module secmon_checks
    import secmon_pkg::*;
#(
    parameter addr_t FW_BASE  = 32'hD000_0000,
    parameter addr_t FW_SIZE  = 32'h0000_0800,
    parameter addr_t RAM_BASE = 32'h4000_0000,
    parameter addr_t RAM_SIZE = 32'h0002_0000,
    parameter addr_t RAM_SPAN = 32'h4000_0000
) (
    input  access_t acc,
    input  window_t win,
    output hits_t   hits
);

    localparam addr_t FW_LAST  = FW_BASE + FW_SIZE - 1;
    localparam addr_t OOB_LO   = RAM_BASE + RAM_SIZE;
    localparam addr_t OOB_HI   = RAM_BASE + RAM_SPAN - 1;

    always_comb begin
        hits.fw_fetch  = acc.valid && acc.fetch && in_span(acc.addr, FW_BASE, FW_LAST);
        hits.ram_oob   = acc.valid && in_span(acc.addr, OOB_LO, OOB_HI);
        hits.win_fetch = acc.valid && acc.fetch && win.armed
                         && in_span(acc.addr, win.first, win.last);
    end

endmodule

// File: rtl/secmon_latch.sv
module secmon_latch
    import secmon_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  hits_t hits,
    output logic  viol
);

    always_ff @(posedge clk) begin
        if (rst) viol <= 1'b0;
        else     viol <= viol | (|hits);
    end

    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (rst)
        viol |=> viol); // R8

endmodule

// File: rtl/exec_guard.sv
module exec_guard
    import secmon_pkg::*;
#(
    parameter addr_t FW_BASE  = 32'hD000_0000,
    parameter addr_t FW_SIZE  = 32'h0000_0800,
    parameter addr_t RAM_BASE = 32'h4000_0000,
    parameter addr_t RAM_SIZE = 32'h0002_0000,
    parameter addr_t RAM_SPAN = 32'h4000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_cs,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        bus_valid,
    input  logic        bus_fetch,
    input  logic [31:0] bus_addr,
    output logic        violation
);

    window_t win;
    access_t acc;
    hits_t   hits;

    assign acc.valid = bus_valid;
    assign acc.fetch = bus_fetch;
    assign acc.addr  = bus_addr;

    secmon_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_cs    (reg_cs),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .win       (win)
    );

    secmon_checks #(
        .FW_BASE  (FW_BASE),
        .FW_SIZE  (FW_SIZE),
        .RAM_BASE (RAM_BASE),
        .RAM_SIZE (RAM_SIZE),
        .RAM_SPAN (RAM_SPAN)
    ) u_checks (
        .acc  (acc),
        .win  (win),
        .hits (hits)
    );

    secmon_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .hits (hits),
        .viol (violation)
    );

    AST_FW_FETCH: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_fetch && in_span(bus_addr, FW_BASE, FW_BASE + FW_SIZE - 1))
        |=> violation); // R2

    AST_RAM_OOB: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && in_span(bus_addr, RAM_BASE + RAM_SIZE, RAM_BASE + RAM_SPAN - 1))
        |=> violation); // R3

    AST_WIN_FETCH: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_fetch && win.armed && in_span(bus_addr, win.first, win.last))
        |=> violation); // R4

    AST_QUIET_DATA: assert property (@(posedge clk) disable iff (rst)
        (!violation && (!bus_valid || (!bus_fetch && bus_addr < RAM_BASE + RAM_SIZE)))
        |=> !violation); // R5

endmodule

// File: tb/exec_guard_tb_top.sv
`timescale 1ns/1ps
module exec_guard_tb_top;

    localparam logic [31:0] FW_BASE  = 32'hD000_0000;
    localparam logic [31:0] FW_SIZE  = 32'h0000_0800;
    localparam logic [31:0] RAM_BASE = 32'h4000_0000;
    localparam logic [31:0] RAM_SIZE = 32'h0002_0000;
    localparam logic [31:0] RAM_SPAN = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_cs = 1'b0, reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        bus_valid = 1'b0, bus_fetch = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        violation;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    exec_guard dut_i (
        .clk(clk), .rst(rst), .reg_cs(reg_cs), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_valid(bus_valid), .bus_fetch(bus_fetch), .bus_addr(bus_addr),
        .violation(violation)
    );

    function automatic bit exp_viol(bit fetch, logic [31:0] a, bit armed,
                                    logic [31:0] f, logic [31:0] l);
        bit v = 1'b0;
        if (fetch && a >= FW_BASE && a <= FW_BASE + FW_SIZE - 1) v = 1'b1;
        if (a >= RAM_BASE + RAM_SIZE && a <= RAM_BASE + RAM_SPAN - 1) v = 1'b1;
        if (fetch && armed && a >= f && a <= l) v = 1'b1;
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_cs = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_cs = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic access(bit fetch, logic [31:0] a);
        @(negedge clk);
        bus_valid = 1'b1; bus_fetch = fetch; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0; bus_fetch = 1'b0;
    endtask

    task automatic one_access(string req, bit armed, logic [31:0] f, logic [31:0] l,
                              bit fetch, logic [31:0] a);
        do_reset();
        wr(8'h61, f);
        wr(8'h62, l);
        if (armed) wr(8'h60, 32'h1);
        access(fetch, a);
        check(req, {31'b0, violation}, {31'b0, exp_viol(fetch, a, armed, f, l)});
    endtask

    function automatic logic [31:0] pick_addr(logic [31:0] f, logic [31:0] l);
        logic [31:0] r = $urandom;
        case (r % 8)
            0: return FW_BASE + (r >> 8) % (FW_SIZE + 4) - 2;
            1: return RAM_BASE + RAM_SIZE - 3 + (r >> 8) % 6;
            2: return f - 2 + (r >> 8) % 5;
            3: return l - 2 + (r >> 8) % 5;
            4: return RAM_BASE + (r >> 8) % RAM_SIZE;
            5: return RAM_BASE + RAM_SPAN - 2 + (r >> 8) % 4;
            6: return f + (r >> 8) % 64;
            default: return r;
        endcase
    endfunction

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240607));
        do_reset();
        // R1 reset state
        check("R1 violation", {31'b0, violation}, 32'h0);
        rd(8'h60, d); check("R1 ctrl", d, 32'h0);
        rd(8'h61, d); check("R1 first", d, 32'h0);
        rd(8'h62, d); check("R1 last", d, 32'h0);

        // R7 load bounds while unarmed, R9 readback and unmapped address
        wr(8'h61, 32'h4000_1000);
        wr(8'h62, 32'h4000_10FF);
        rd(8'h61, d); check("R7 first load", d, 32'h4000_1000);
        rd(8'h62, d); check("R7 last load", d, 32'h4000_10FF);
        rd(8'h63, d); check("R9 unmapped", d, 32'h0);
        rd(8'h00, d); check("R9 unmapped 0", d, 32'h0);

        // R5 window fetch while unarmed, data in window and in fw RAM
        access(1'b1, 32'h4000_1000);
        check("R5 unarmed fetch", {31'b0, violation}, 32'h0);
        wr(8'h60, 32'h0);
        rd(8'h60, d); check("R6 zero write no arm", d, 32'h0);
        wr(8'h60, 32'h1);
        rd(8'h60, d); check("R6 armed", d, 32'h1);
        access(1'b0, 32'h4000_1000);
        access(1'b0, 32'h4000_10FF);
        access(1'b0, FW_BASE);
        access(1'b1, 32'h4000_0FFF);
        access(1'b1, 32'h4000_1100);
        access(1'b0, RAM_BASE + RAM_SIZE - 1);
        check("R5 data and edges quiet", {31'b0, violation}, 32'h0);

        // R6 no disarm, R7 bounds locked
        wr(8'h60, 32'h0);
        rd(8'h60, d); check("R6 no disarm", d, 32'h1);
        wr(8'h61, 32'h4000_5000);
        wr(8'h62, 32'h4000_6000);
        rd(8'h61, d); check("R7 first locked", d, 32'h4000_1000);
        rd(8'h62, d); check("R7 last locked", d, 32'h4000_10FF);
        access(1'b1, 32'h4000_5800);
        check("R7 locked bounds used", {31'b0, violation}, 32'h0);

        // R4 inclusive upper edge, R8 sticky
        access(1'b1, 32'h4000_10FF);
        check("R4 last edge", {31'b0, violation}, 32'h1);
        access(1'b0, 32'h4000_0000);
        @(negedge clk); @(negedge clk);
        check("R8 sticky", {31'b0, violation}, 32'h1);
        do_reset();
        check("R8 cleared by reset", {31'b0, violation}, 32'h0);

        // directed region edges
        one_access("R4 first edge", 1'b1, 32'h4000_2000, 32'h4000_2010, 1'b1, 32'h4000_2000);
        one_access("R4 empty window", 1'b1, 32'h4000_2010, 32'h4000_2000, 1'b1, 32'h4000_2008);
        one_access("R2 fw base", 1'b0, 32'h0, 32'h0, 1'b1, FW_BASE);
        one_access("R2 fw last", 1'b0, 32'h0, 32'h0, 1'b1, FW_BASE + FW_SIZE - 1);
        one_access("R2 fw past end", 1'b0, 32'h0, 32'h0, 1'b1, FW_BASE + FW_SIZE);
        one_access("R3 oob data", 1'b0, 32'h0, 32'h0, 1'b0, RAM_BASE + RAM_SIZE);
        one_access("R3 oob fetch top", 1'b0, 32'h0, 32'h0, 1'b1, RAM_BASE + RAM_SPAN - 1);
        one_access("R3 above span", 1'b0, 32'h0, 32'h0, 1'b0, RAM_BASE + RAM_SPAN);
        one_access("R3 last valid", 1'b0, 32'h0, 32'h0, 1'b1, RAM_BASE + RAM_SIZE - 1);

        // constrained random trials
        for (int i = 0; i < 300; i++) begin
            logic [31:0] f = RAM_BASE + ($urandom % RAM_SIZE);
            logic [31:0] l = ($urandom % 8 == 0) ? f - 1 - ($urandom % 16) : f + ($urandom % 1024);
            bit armed = $urandom % 4 != 0;
            bit fetch = $urandom % 2;
            logic [31:0] a = pick_addr(f, l);
            one_access("R2 R3 R4 R5 random", armed, f, l, fetch, a);
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule